// File: doc/BRIEF.md
# SMI Arbitration and SMM State Controller

This block decides when a processor core enters and leaves system management mode. Two request sources can ask for a system management interrupt: a dedicated pin and a message delivered through the local interrupt controller. Either one sets a single pending flag. The block holds that flag until an instruction boundary is reported, and then switches the core into the mode. The mode can be left only through a resume strobe, or by reset. The block also arbitrates between the SMI request, a non-maskable interrupt and a maskable interrupt. It reports which of them the core accepts at each boundary.

The resume strobe carries a flag that says whether the restored context was valid. A resume with an invalid context sends the block into a shutdown state that holds until reset. A resume issued while the core is outside the mode is reported as an invalid-opcode fault. A counter records every entry into the mode. Saving context, decoding the protected memory window and coordinating several cores are handled elsewhere.

Top module: `smm_ctrl`

## Requirements
- R1: After reset, every pulse output is 0, `in_smm` and `shut_down` are 0, and `smi_count` is 0.
- R2: A request on `smi_pin_req` or on `smi_apic_req` sets one shared pending SMI flag on the next clock edge. An `insn_bnd` cycle seen with the flag set enters the mode: at that edge `smm_enter` pulses high for one cycle, `in_smm` rises, and the flag clears.
- R3: `if_flag` has no effect on a pending SMI: entry takes place with `if_flag` at 0.
- R4: Entry happens only at an `insn_bnd` cycle in which the flag was already pending. A request given in the same cycle as a boundary waits for the next boundary, and a pending request survives any number of cycles without a boundary.
- R5: At a boundary where both an SMI and an NMI are pending, only the SMI is serviced. The NMI stays pending.
- R6: An `nmi_req` presented in the same cycle as an SMI request is discarded and is never accepted.
- R7: While `in_smm` is 1, boundaries produce no entry, no `nmi_take` and no `intr_take`. SMI and NMI requests that arrive are still latched. A latched SMI is serviced at the first boundary after exit.
- R8: `rsm_exec` with `state_ok` at 1 while `in_smm` is 1 clears `in_smm` at the next edge.
- R9: `rsm_exec` while outside the mode and not shut down gives a one-cycle `ud_fault` pulse at the next edge. Mode and counter are left unchanged.
- R10: `rsm_exec` with `state_ok` at 0 while in the mode clears `in_smm` and sets `shut_down`. That state holds until reset. In shutdown there is no entry, no accept and no fault pulse.
- R11: `smi_count` rises by one, modulo 2^CNT_W, at the same edge as each `smm_enter` pulse, and holds otherwise.
- R12: Outside the mode, at a boundary with no SMI pending, a pending NMI is accepted first (`nmi_take` pulse). Otherwise `intr_take` pulses only if `intr_req` and `if_flag` are both 1 in that cycle. A maskable interrupt is a level and is not latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smi_pin_req | input | 1 | SMI request from the dedicated pin |
| smi_apic_req | input | 1 | SMI request delivered by the interrupt controller |
| nmi_req | input | 1 | Non-maskable interrupt request |
| intr_req | input | 1 | Maskable interrupt request level |
| if_flag | input | 1 | Interrupt-enable flag of the core |
| insn_bnd | input | 1 | Instruction-boundary strobe |
| rsm_exec | input | 1 | Resume instruction executed |
| state_ok | input | 1 | Restored context is valid (qualifies `rsm_exec`) |
| smm_enter | output | 1 | One-cycle pulse on entry to the mode |
| in_smm | output | 1 | Core is in system management mode |
| nmi_take | output | 1 | One-cycle pulse, NMI accepted |
| intr_take | output | 1 | One-cycle pulse, maskable interrupt accepted |
| ud_fault | output | 1 | One-cycle invalid-opcode pulse |
| shut_down | output | 1 | Sticky shutdown state |
| smi_count | output | CNT_W | Count of entries into the mode |

## Verification
The hardest case to reach from the ports is an SMI and an NMI that are both pending when the core leaves the mode. The stimulus builds it inside the mode. It raises an NMI and a second SMI, through the interrupt-controller path, during the mode's body, where neither can be accepted. It then resumes with a valid context and presents a boundary together with an enabled maskable interrupt. That boundary must re-enter the mode. The next two boundaries after the following exit must take the NMI and then the maskable interrupt. A second sequence presents an NMI in the same cycle as an SMI request and shows that the NMI never appears, even once the core is back outside the mode.

// File: rtl/smm_pkg.sv
package smm_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'd0,
    MODE_SMM      = 2'd1,
    MODE_SHUTDOWN = 2'd2
  } smm_mode_e;

  typedef struct packed {
    logic go_smm;
    logic go_nmi;
    logic go_intr;
  } smm_grant_t;

  // Fixed priority at a boundary: SMI, then NMI, then maskable interrupt.
  function automatic smm_grant_t pick_grant(
    input smm_mode_e mode,
    input logic      bnd,
    input logic      smi_p,
    input logic      nmi_p,
    input logic      intr,
    input logic      ien
  );
    smm_grant_t g;
    g = '0;
    if (mode == MODE_NORMAL && bnd) begin
      if (smi_p)            g.go_smm  = 1'b1;
      else if (nmi_p)       g.go_nmi  = 1'b1;
      else if (intr && ien) g.go_intr = 1'b1;
    end
    return g;
  endfunction

endpackage

// File: rtl/smm_req_latch.sv
module smm_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic smi_src_a,
  input  logic smi_src_b,
  input  logic nmi_in,
  input  logic smi_served,
  input  logic nmi_served,
  output logic smi_pend,
  output logic nmi_pend
);
  logic smi_any;
  logic smi_pend_d;
  logic nmi_pend_d;

  assign smi_any = smi_src_a | smi_src_b;

  // An NMI arriving alongside an SMI request is dropped.
  assign smi_pend_d = (smi_pend & ~smi_served) | smi_any;
  assign nmi_pend_d = (nmi_pend & ~nmi_served) | (nmi_in & ~smi_any);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smi_pend <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      smi_pend <= smi_pend_d;
      nmi_pend <= nmi_pend_d;
    end
  end
endmodule

// File: rtl/smm_mode_fsm.sv
module smm_mode_fsm
  import smm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  smm_grant_t grant,
  input  logic       rsm_exec,
  input  logic       state_ok,
  output smm_mode_e  mode,
  output logic       enter_q,
  output logic       nmi_q,
  output logic       intr_q,
  output logic       ud_q
);
  smm_mode_e mode_d;
  logic      ud_d;

  always_comb begin
    mode_d = mode;
    ud_d   = 1'b0;
    unique case (mode)
      MODE_NORMAL: begin
        if (grant.go_smm) mode_d = MODE_SMM;
        ud_d = rsm_exec;
      end
      MODE_SMM: begin
        if (rsm_exec) mode_d = state_ok ? MODE_NORMAL : MODE_SHUTDOWN;
      end
      default: mode_d = MODE_SHUTDOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= MODE_NORMAL;
      enter_q <= 1'b0;
      nmi_q   <= 1'b0;
      intr_q  <= 1'b0;
      ud_q    <= 1'b0;
    end else begin
      mode    <= mode_d;
      enter_q <= grant.go_smm;
      nmi_q   <= grant.go_nmi;
      intr_q  <= grant.go_intr;
      ud_q    <= ud_d;
    end
  end
endmodule

// File: rtl/smm_entry_counter.sv
module smm_entry_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v);
    return v + ONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (bump) count <= step(count);
  end
endmodule

// File: rtl/smm_ctrl.sv
module smm_ctrl
  import smm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smi_pin_req,
  input  logic             smi_apic_req,
  input  logic             nmi_req,
  input  logic             intr_req,
  input  logic             if_flag,
  input  logic             insn_bnd,
  input  logic             rsm_exec,
  input  logic             state_ok,
  output logic             smm_enter,
  output logic             in_smm,
  output logic             nmi_take,
  output logic             intr_take,
  output logic             ud_fault,
  output logic             shut_down,
  output logic [CNT_W-1:0] smi_count
);
  smm_mode_e  mode;
  smm_grant_t grant;
  logic       smi_pend;
  logic       nmi_pend;
  logic       go_smm;
  logic       go_nmi;
  logic       go_intr;

  smm_req_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .smi_src_a  (smi_pin_req),
    .smi_src_b  (smi_apic_req),
    .nmi_in     (nmi_req),
    .smi_served (go_smm),
    .nmi_served (go_nmi),
    .smi_pend   (smi_pend),
    .nmi_pend   (nmi_pend)
  );

  assign grant   = pick_grant(mode, insn_bnd, smi_pend, nmi_pend, intr_req, if_flag);
  assign go_smm  = grant.go_smm;
  assign go_nmi  = grant.go_nmi;
  assign go_intr = grant.go_intr;

  smm_mode_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant    (grant),
    .rsm_exec (rsm_exec),
    .state_ok (state_ok),
    .mode     (mode),
    .enter_q  (smm_enter),
    .nmi_q    (nmi_take),
    .intr_q   (intr_take),
    .ud_q     (ud_fault)
  );

  smm_entry_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (go_smm),
    .count (smi_count)
  );

  assign in_smm    = (mode == MODE_SMM);
  assign shut_down = (mode == MODE_SHUTDOWN);
endmodule

// File: rtl/smm_ctrl_chk.sv
module smm_ctrl_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smi_pin_req,
  input logic             smi_apic_req,
  input logic             nmi_req,
  input logic             intr_req,
  input logic             if_flag,
  input logic             insn_bnd,
  input logic             rsm_exec,
  input logic             state_ok,
  input logic             smm_enter,
  input logic             in_smm,
  input logic             nmi_take,
  input logic             intr_take,
  input logic             ud_fault,
  input logic             shut_down,
  input logic [CNT_W-1:0] smi_count,
  input logic             smi_pend,
  input logic             nmi_pend
);
  a_r2_req_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_pin_req || smi_apic_req) |=> smi_pend);

  a_r4_enter_at_bnd: assert property (@(posedge clk) disable iff (!rst_n)
    smm_enter |-> ($past(insn_bnd) && $past(smi_pend) && in_smm));

  a_r5_smi_first: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take |-> !$past(smi_pend));

  a_r6_nmi_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && (smi_pin_req || smi_apic_req) && !nmi_pend) |=> !nmi_pend);

  a_r7_quiet_in_smm: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_smm) |-> !(smm_enter || nmi_take || intr_take));

  a_r8_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (in_smm && rsm_exec && state_ok) |=> (!in_smm && !shut_down));

  a_r9_ud_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (rsm_exec && !in_smm && !shut_down) |=> ud_fault);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    shut_down |=> (shut_down && !in_smm && !ud_fault));

  a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    smm_enter |-> (smi_count == $past(smi_count) + CNT_W'(1)));

  a_r11_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smm_enter |-> $stable(smi_count));

  a_r12_intr_gate: assert property (@(posedge clk) disable iff (!rst_n)
    intr_take |-> $past(intr_req && if_flag && !nmi_pend));

  a_r12_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({smm_enter, nmi_take, intr_take}));
endmodule

bind smm_ctrl smm_ctrl_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_smm_ctrl.sv
module tb_smm_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smi_pin_req = 0, smi_apic_req = 0, nmi_req = 0, intr_req = 0;
  logic        if_flag = 0, insn_bnd = 0, rsm_exec = 0, state_ok = 0;
  logic        smm_enter, in_smm, nmi_take, intr_take, ud_fault, shut_down;
  logic [31:0] smi_count;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  smm_ctrl dut (.*);

  // Inputs  [7:0]: pin, apic, nmi, intr, ien, bnd, rsm, ok
  // Outputs [5:0]: enter, in, nmi_take, intr_take, ud, shut
  // Count   [3:0]: expected entry count after the edge
  localparam int NV = 28;
  localparam logic [17:0] VEC [NV] = '{
    {8'b00000000, 6'b000000, 4'd0}, // 0  idle after reset
    {8'b10000000, 6'b000000, 4'd0}, // 1  pin request
    {8'b00000100, 6'b110000, 4'd1}, // 2  R2 R3 enter with ien=0
    {8'b00000000, 6'b010000, 4'd1}, // 3  stay in mode
    {8'b00111100, 6'b010000, 4'd1}, // 4  R7 nmi+intr at boundary in mode
    {8'b01000000, 6'b010000, 4'd1}, // 5  R7 apic request in mode
    {8'b00000011, 6'b000000, 4'd1}, // 6  R8 resume ok
    {8'b00011100, 6'b110000, 4'd2}, // 7  R5 R7 SMI beats pending NMI
    {8'b00000011, 6'b000000, 4'd2}, // 8  R8 resume ok
    {8'b00011100, 6'b001000, 4'd2}, // 9  R12 NMI before INTR
    {8'b00011100, 6'b000100, 4'd2}, // 10 R12 INTR taken
    {8'b00010100, 6'b000000, 4'd2}, // 11 R12 INTR masked by ien=0
    {8'b10100000, 6'b000000, 4'd2}, // 12 R6 NMI with SMI same cycle
    {8'b00000100, 6'b110000, 4'd3}, // 13 R2 enter
    {8'b00000011, 6'b000000, 4'd3}, // 14 resume
    {8'b00000100, 6'b000000, 4'd3}, // 15 R6 dropped NMI never taken
    {8'b10000000, 6'b000000, 4'd3}, // 16 R4 request
    {8'b00000000, 6'b000000, 4'd3}, // 17 R4 no boundary
    {8'b00000000, 6'b000000, 4'd3}, // 18 R4 no boundary
    {8'b00000100, 6'b110000, 4'd4}, // 19 R4 R11 enter
    {8'b00000011, 6'b000000, 4'd4}, // 20 resume
    {8'b00000010, 6'b000010, 4'd4}, // 21 R9 resume outside
    {8'b00000000, 6'b000000, 4'd4}, // 22 R9 one-cycle pulse
    {8'b01000000, 6'b000000, 4'd4}, // 23 apic request
    {8'b00000100, 6'b110000, 4'd5}, // 24 R2 enter via apic
    {8'b00000010, 6'b000001, 4'd5}, // 25 R10 resume, bad context
    {8'b10100000, 6'b000001, 4'd5}, // 26 R10 requests ignored
    {8'b00011111, 6'b000001, 4'd5}  // 27 R10 no fault, no accept
  };
  localparam int TAG [NV] = '{1, 2, 3, 7, 7, 7, 8, 5, 8, 12, 12, 12, 6, 2,
                              8, 6, 4, 4, 4, 11, 8, 9, 9, 2, 2, 10, 10, 10};

  task automatic drive(input logic [7:0] v);
    {smi_pin_req, smi_apic_req, nmi_req, intr_req,
     if_flag, insn_bnd, rsm_exec, state_ok} = v;
  endtask

  task automatic check(input int tag, input logic [5:0] exp_o, input int exp_c);
    logic [5:0] got;
    got = {smm_enter, in_smm, nmi_take, intr_take, ud_fault, shut_down};
    total++;
    if (got !== exp_o || smi_count !== 32'(exp_c)) begin
      bad++;
      $display("FAIL R%0d outputs=%b count=%0d expected outputs=%b count=%0d",
               tag, got, smi_count, exp_o, exp_c);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, 6'b000000, 0);              // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check(1, 6'b000000, 0);              // R1 after release

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][17:10]);
      @(negedge clk);
      check(TAG[i], VEC[i][9:4], int'(VEC[i][3:0]));
    end
    drive(8'h00);

    // R10 shutdown holds over idle cycles, reset clears it (R1)
    repeat (3) @(negedge clk);
    check(10, 6'b000001, 5);
    rst_n = 1'b0;
    @(negedge clk);
    check(1, 6'b000000, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 request in the same cycle as a boundary waits for the next one
    drive(8'b10000100);
    @(negedge clk);
    check(4, 6'b000000, 0);
    drive(8'b00000100);
    @(negedge clk);
    check(4, 6'b110000, 1);
    drive(8'b00000000);
    @(negedge clk);
    check(11, 6'b010000, 1);             // R11 count holds without entry

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule